// File: doc/BRIEF.md
# Mixed-Length Instruction Word Decoder

This block sits between instruction fetch and execute in a small 8-bit RISC core. Each cycle it may accept one 16-bit program word. It works out which encoding format the word uses and gathers the operand bits, which are scattered over the word, into plain fields. These are a destination register, a source register, a 22-bit value (constant, I/O address or memory address), an opcode slice and one variant bit.

Two formats take two words: the long jump/call and the direct memory access. When the first word of either arrives, the decoder keeps it and waits for the next accepted word, which may come any number of idle cycles later. It then issues one merged result. A flush drops a pending first word, and also drops a word presented in the same cycle. Results are registered, and `valid_o` pulses once per finished instruction.

Top module: `instr_decoder`

## Requirements
- R1: After a synchronous reset, `valid_o` is 0 and every output field reads 0 until a word is accepted.
- R2: A word with [15:12] equal to 1 or 2, or with [15:12]=0 and [11:10] non-zero, gives format code 1. `op_o`=[15:10], `dst_o`={[8],[7:4]} and `src_o`={[9],[3:0]}.
- R3: A word with [15:12] in {3,4,5,6,7,14} gives code 2. `op_o`=[15:12] with zero extension, `dst_o`=16+[7:4] and `value_o`={[11:8],[3:0]}.
- R4: A word with [15:9]=1001011 gives code 3. `dst_o`=24+2·[5:4], `value_o`={[7:6],[3:0]} and `sel_o`=[8] (1 means subtract).
- R5: A word with [15:8]=00000001 gives code 4. `dst_o`=2·[7:4] and `src_o`=2·[3:0].
- R6: A word with [15:11]=10110 gives code 5 (read from I/O), and [15:11]=10111 gives code 6 (write to I/O). In both, `dst_o`={[8],[7:4]} and `value_o`={[10:9],[3:0]}.
- R7: A first word with [15:9]=1001010 and [3:2]=11 starts a long jump/call, code 7. The result is issued after the next accepted word, with `value_o`={first[8:4], first[0], second[15:0]} and `sel_o`=first[1] (1 means call).
- R8: A first word with [15:10]=100100 and [3:0]=0000 starts a direct memory access, code 8. The result is issued after the next accepted word, with `dst_o`={first[8],first[7:4]}, `value_o`=second word and `sel_o`=first[9] (1 means store).
- R9: Any other word gives code 0 with `illegal_o`=1 together with its valid pulse. In every format, fields that the format does not define read 0.
- R10: When `flush_i` is high, any pending first word is discarded, and so is a word presented in the same cycle. `valid_o` is 0 in the following cycle, and the next word is decoded afresh.
- R11: `valid_o` is high for exactly one cycle per instruction, in the cycle after its last word is accepted. Idle cycles between the two words of a long instruction are allowed, and single-word instructions may arrive back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| word_vld_i | input | 1 | Program word present this cycle |
| flush_i | input | 1 | Discard pending and current words |
| word_i | input | 16 | Program word |
| valid_o | output | 1 | One-cycle pulse per decoded instruction |
| illegal_o | output | 1 | Word matched no format |
| fmt_o | output | 4 | Format code |
| op_o | output | 6 | Opcode slice of the first word |
| dst_o | output | 5 | Destination / transfer register number |
| src_o | output | 5 | Source register number |
| value_o | output | 22 | Constant, I/O address or memory address |
| sel_o | output | 1 | Variant bit (subtract, call, store) |

## Verification
Every one of the 65,536 word values is applied as a first word. When a value starts a long instruction, a derived second word follows it, so each format's scattered field positions are compared against arithmetic extraction and every gap between formats is shown to fall into the illegal code. Directed sequences cover the rest. Back-to-back single words show that nothing is held over between instructions. An idle gap inside a memory-access pair shows that the pending word survives waiting. Flushes placed with no word, with a single word, and with a second word show that pending state and same-cycle words are both dropped.

// File: rtl/instr_dec_pkg.sv
package instr_dec_pkg;

    localparam int WORD_W = 16;
    localparam int REG_W  = 5;
    localparam int OP_W   = 6;
    localparam int VAL_W  = 22;
    localparam int FMT_W  = 4;
    localparam int HI_W   = VAL_W - WORD_W;

    typedef enum logic [FMT_W-1:0] {
        FMT_BAD   = 4'd0,
        FMT_RR    = 4'd1,
        FMT_RIMM  = 4'd2,
        FMT_WIMM  = 4'd3,
        FMT_PAIR  = 4'd4,
        FMT_IOIN  = 4'd5,
        FMT_IOOUT = 4'd6,
        FMT_LJMP  = 4'd7,
        FMT_DMEM  = 4'd8
    } fmt_e;

    typedef struct packed {
        fmt_e             fmt;
        logic             two_word;
        logic             sel;
        logic [OP_W-1:0]  op;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] src;
        logic [VAL_W-1:0] value;
    } dec_t;

    // Format classification; the tested patterns do not overlap.
    function automatic fmt_e classify(input logic [WORD_W-1:0] w);
        fmt_e f;
        if ((w[15:12] == 4'h0 && w[11:10] != 2'b00) || w[15:12] == 4'h1 || w[15:12] == 4'h2)
            f = FMT_RR;
        else if (w[15:8] == 8'h01)
            f = FMT_PAIR;
        else if (w[15:12] inside {4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hE})
            f = FMT_RIMM;
        else if (w[15:9] == 7'b1001011)
            f = FMT_WIMM;
        else if (w[15:9] == 7'b1001010 && w[3:2] == 2'b11)
            f = FMT_LJMP;
        else if (w[15:10] == 6'b100100 && w[3:0] == 4'h0)
            f = FMT_DMEM;
        else if (w[15:11] == 5'b10110)
            f = FMT_IOIN;
        else if (w[15:11] == 5'b10111)
            f = FMT_IOOUT;
        else
            f = FMT_BAD;
        return f;
    endfunction

    // Register number built from a split high bit and a low nibble.
    function automatic logic [REG_W-1:0] split_reg(input logic hi, input logic [3:0] lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/dec_fields.sv
module dec_fields
    import instr_dec_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output dec_t              dec
);
    always_comb begin
        dec     = '0;
        dec.fmt = classify(word);
        case (dec.fmt)
            FMT_RR: begin
                dec.op  = word[15:10];
                dec.dst = split_reg(word[8], word[7:4]);
                dec.src = split_reg(word[9], word[3:0]);
            end
            FMT_RIMM: begin
                dec.op    = OP_W'(word[15:12]);
                dec.dst   = {1'b1, word[7:4]};
                dec.value = VAL_W'({word[11:8], word[3:0]});
            end
            FMT_WIMM: begin
                dec.dst   = {2'b11, word[5:4], 1'b0};
                dec.value = VAL_W'({word[7:6], word[3:0]});
                dec.sel   = word[8];
            end
            FMT_PAIR: begin
                dec.dst = {word[7:4], 1'b0};
                dec.src = {word[3:0], 1'b0};
            end
            FMT_IOIN, FMT_IOOUT: begin
                dec.dst   = split_reg(word[8], word[7:4]);
                dec.value = VAL_W'({word[10:9], word[3:0]});
            end
            FMT_LJMP: begin
                dec.two_word = 1'b1;
                dec.sel      = word[1];
                dec.value    = {word[8:4], word[0], {WORD_W{1'b0}}};
            end
            FMT_DMEM: begin
                dec.two_word = 1'b1;
                dec.sel      = word[9];
                dec.dst      = split_reg(word[8], word[7:4]);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dec_track.sv
module dec_track
    import instr_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              vld,
    input  logic              flush,
    input  logic [WORD_W-1:0] word,
    input  dec_t              cur,
    output logic              fire,
    output dec_t              out
);
    logic pend_q, pend_d;
    dec_t hold_q, hold_d;

    always_comb begin
        fire   = 1'b0;
        out    = cur;
        pend_d = pend_q;
        hold_d = hold_q;
        if (flush) begin
            pend_d = 1'b0;
        end else if (vld) begin
            if (pend_q) begin
                fire      = 1'b1;
                out       = hold_q;
                out.value = hold_q.value | VAL_W'(word);
                pend_d    = 1'b0;
            end else if (cur.two_word) begin
                pend_d = 1'b1;
                hold_d = cur;
            end else begin
                fire = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            hold_q <= '0;
        end else begin
            pend_q <= pend_d;
            hold_q <= hold_d;
        end
    end

    // R10
    flush_drops_pending_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> !pend_q);

    // R7
    first_word_waits_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && !flush && !pend_q && cur.two_word) |=> pend_q);

    // R11
    pair_completes_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && vld && !flush) |-> fire);
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
    import instr_dec_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              word_vld_i,
    input  logic              flush_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              valid_o,
    output logic              illegal_o,
    output logic [FMT_W-1:0]  fmt_o,
    output logic [OP_W-1:0]   op_o,
    output logic [REG_W-1:0]  dst_o,
    output logic [REG_W-1:0]  src_o,
    output logic [VAL_W-1:0]  value_o,
    output logic              sel_o
);
    dec_t cur_dec, done_dec;
    logic fire;

    dec_fields u_fields (
        .word (word_i),
        .dec  (cur_dec)
    );

    dec_track u_track (
        .clk   (clk_i),
        .rst   (rst_i),
        .vld   (word_vld_i),
        .flush (flush_i),
        .word  (word_i),
        .cur   (cur_dec),
        .fire  (fire),
        .out   (done_dec)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            valid_o   <= 1'b0;
            illegal_o <= 1'b0;
            fmt_o     <= '0;
            op_o      <= '0;
            dst_o     <= '0;
            src_o     <= '0;
            value_o   <= '0;
            sel_o     <= 1'b0;
        end else begin
            valid_o <= fire;
            if (fire) begin
                illegal_o <= (done_dec.fmt == FMT_BAD);
                fmt_o     <= done_dec.fmt;
                op_o      <= done_dec.op;
                dst_o     <= done_dec.dst;
                src_o     <= done_dec.src;
                value_o   <= done_dec.value;
                sel_o     <= done_dec.sel;
            end
        end
    end

    // R10
    flush_no_output_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        flush_i |=> !valid_o);

    // R11
    valid_has_word_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> $past(word_vld_i && !flush_i));

    // R3
    rimm_upper_bank_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_o && fmt_o == FMT_RIMM) |-> dst_o[REG_W-1]);

    // R4
    wimm_pair_reg_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_o && fmt_o == FMT_WIMM) |-> (dst_o[REG_W-1:REG_W-2] == 2'b11 && !dst_o[0]));

    // R5
    pair_even_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_o && fmt_o == FMT_PAIR) |-> (!dst_o[0] && !src_o[0]));
endmodule

// File: tb/sim_instr_decoder.sv
module sim_instr_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vld = 1'b0;
    logic        flush = 1'b0;
    logic [15:0] word = 16'h0;
    logic        valid_o, illegal_o, sel_o;
    logic [3:0]  fmt_o;
    logic [5:0]  op_o;
    logic [4:0]  dst_o, src_o;
    logic [21:0] value_o;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;
    int m_fmt, m_two, m_sel, m_op, m_dst, m_src, m_val;

    always #4 clk = ~clk;

    instr_decoder u0 (
        .clk_i(clk), .rst_i(rst), .word_vld_i(vld), .flush_i(flush), .word_i(word),
        .valid_o(valid_o), .illegal_o(illegal_o), .fmt_o(fmt_o), .op_o(op_o),
        .dst_o(dst_o), .src_o(src_o), .value_o(value_o), .sel_o(sel_o)
    );

    // Arithmetic reference from the requirement encodings.
    task automatic model(input int w, input int w2);
        int hi, lo4, mid4, b8, b9;
        hi = w / 4096; lo4 = w % 16; mid4 = (w / 16) % 16;
        b8 = (w / 256) % 2; b9 = (w / 512) % 2;
        m_fmt = 0; m_two = 0; m_sel = 0; m_op = 0; m_dst = 0; m_src = 0; m_val = 0;
        if ((hi == 0 && ((w / 1024) % 4) != 0) || hi == 1 || hi == 2) begin
            m_fmt = 1; m_op = w / 1024; m_dst = b8 * 16 + mid4; m_src = b9 * 16 + lo4;
        end else if (w / 256 == 1) begin
            m_fmt = 4; m_dst = mid4 * 2; m_src = lo4 * 2;
        end else if ((hi >= 3 && hi <= 7) || hi == 14) begin
            m_fmt = 2; m_op = hi; m_dst = 16 + mid4; m_val = ((w / 256) % 16) * 16 + lo4;
        end else if (w / 512 == 75) begin
            m_fmt = 3; m_dst = 24 + ((w / 16) % 4) * 2; m_val = ((w / 64) % 4) * 16 + lo4; m_sel = b8;
        end else if (w / 512 == 74 && ((w / 4) % 4) == 3) begin
            m_fmt = 7; m_two = 1; m_sel = (w / 2) % 2;
            m_val = (((w / 16) % 32) * 2 + (w % 2)) * 65536 + w2;
        end else if (w / 1024 == 36 && lo4 == 0) begin
            m_fmt = 8; m_two = 1; m_sel = b9; m_dst = b8 * 16 + mid4; m_val = w2;
        end else if (w / 2048 == 22) begin
            m_fmt = 5; m_dst = b8 * 16 + mid4; m_val = ((w / 512) % 4) * 16 + lo4;
        end else if (w / 2048 == 23) begin
            m_fmt = 6; m_dst = b8 * 16 + mid4; m_val = ((w / 512) % 4) * 16 + lo4;
        end
    endtask

    function automatic string tag_of(input int f);
        case (f)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5, 6: return "R6";
            7: return "R7";
            8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic compare(input string req);
        nvec++;
        if (valid_o !== 1'b1 || fmt_o !== m_fmt[3:0] || illegal_o !== (m_fmt == 0) ||
            sel_o !== m_sel[0] || op_o !== m_op[5:0] || dst_o !== m_dst[4:0] ||
            src_o !== m_src[4:0] || value_o !== m_val[21:0]) begin
            nbad++;
            $display("FAIL %s: got v=%0b fmt=%0d ill=%0b op=%0h dst=%0d src=%0d val=%0h sel=%0b exp v=1 fmt=%0d op=%0h dst=%0d src=%0d val=%0h sel=%0d",
                     req, valid_o, fmt_o, illegal_o, op_o, dst_o, src_o, value_o, sel_o,
                     m_fmt, m_op, m_dst, m_src, m_val, m_sel);
        end
    endtask

    task automatic check_low(input string req);
        nvec++;
        if (valid_o !== 1'b0) begin
            nbad++;
            $display("FAIL %s: valid_o got %0b exp 0", req, valid_o);
        end
    endtask

    // Applies one instruction at a negedge; returns at the negedge after the result.
    task automatic run_instr(input int w, input int w2);
        model(w, w2);
        vld = 1'b1; word = w[15:0];
        @(negedge clk);
        if (m_two == 1) begin
            check_low("R7");
            word = w2[15:0];
            @(negedge clk);
        end
        vld = 1'b0;
        compare(tag_of(m_fmt));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        nvec++;
        if (valid_o !== 0 || illegal_o !== 0 || fmt_o !== 0 || op_o !== 0 || dst_o !== 0 ||
            src_o !== 0 || value_o !== 0 || sel_o !== 0) begin
            nbad++;
            $display("FAIL R1: got v=%0b fmt=%0d val=%0h exp all zero", valid_o, fmt_o, value_o);
        end

        // Full sweep of every first-word value (R2..R9)
        for (int w = 0; w < 65536; w++) begin
            run_instr(w, (w * 7 + 13) % 65536);
            @(negedge clk);
        end

        // R11: back-to-back single words, then one-cycle pulse
        model(16'h0C12, 0);
        vld = 1'b1; word = 16'h0C12;
        @(negedge clk);
        compare("R11");
        model(16'hE5A7, 0);
        word = 16'hE5A7;
        @(negedge clk);
        vld = 1'b0;
        compare("R11");
        @(negedge clk);
        check_low("R11");

        // R11: idle gap inside a memory-access pair (R8 fields)
        model(16'h9300, 16'h1234);
        vld = 1'b1; word = 16'h9300;
        @(negedge clk);
        vld = 1'b0; word = 16'hFFFF;
        for (int i = 0; i < 3; i++) begin
            check_low("R11");
            @(negedge clk);
        end
        check_low("R11");
        vld = 1'b1; word = 16'h1234;
        @(negedge clk);
        vld = 1'b0;
        compare("R8");
        @(negedge clk);
        check_low("R11");

        // R10: flush with no word after a pending first word
        vld = 1'b1; word = 16'h940E;
        @(negedge clk);
        vld = 1'b0; flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        check_low("R10");
        run_instr(16'h2C3F, 0);
        @(negedge clk);

        // R10: flush together with a single word
        vld = 1'b1; flush = 1'b1; word = 16'h1F0F;
        @(negedge clk);
        vld = 1'b0; flush = 1'b0;
        check_low("R10");
        @(negedge clk);
        check_low("R10");

        // R10: flush together with the second word, then fresh decode
        vld = 1'b1; word = 16'h95FD;
        @(negedge clk);
        flush = 1'b1; word = 16'hB123;
        @(negedge clk);
        vld = 1'b0; flush = 1'b0;
        check_low("R10");
        run_instr(16'hB123, 0);
        @(negedge clk);

        finish_run();
    end
endmodule